// File: doc/BRIEF.md
# MIDI Serial Port with Command-Acknowledge Protocol

This block is a byte-wide host port for a MIDI line. The host sees two registers selected by one address bit. The data register (address 0) is read to take the oldest received byte and written to send one byte. The command/status register (address 1) is written with commands and read for two active-low flags. Transmitted bytes leave on the serial output as 8N1 frames. Serial input is decoded into a small receive FIFO.

After reset the port sits in command-only mode. It carries no MIDI traffic until the host writes the pass-through command. Both accepted commands answer in-band: an acknowledge byte of 0xFE appears in the receive FIFO, and the host reads it back the same way as MIDI data. An interrupt request stays high while the FIFO holds bytes. While unread input is pending the transmitter reports itself not ready, so the host must drain input before it writes.

Top module: `midi_uart_port`

## Requirements
- R1: Reading address 1 returns status. Bit 7 is 1 exactly when the receive FIFO is empty. Bit 6 is 1 exactly when a data write would be refused, that is, when the transmitter is busy or the FIFO is not empty. Bits 5..0 read 0.
- R2: Writing 0xFF to address 1 empties the receive FIFO, clears the overflow flag and leaves pass-through mode. In the following cycle the FIFO holds exactly one byte, 0xFE.
- R3: Writing 0x3F to address 1 enters pass-through mode and appends 0xFE to the receive FIFO.
- R4: Reading address 0 returns the oldest FIFO byte and removes it, so bytes come out in arrival order. Reading address 0 with the FIFO empty returns 0x00 and changes nothing.
- R5: An accepted byte is sent as one low start bit, eight data bits LSB first and one high stop bit. Each bit lasts CLK_HZ/BAUD clocks. The line idles high.
- R6: A data write made while status bit 6 is 1 is discarded and produces no frame.
- R7: Outside pass-through mode, data writes produce no frame and serial input bytes are not stored.
- R8: In pass-through mode, each serial frame with a high stop bit appends its byte to the FIFO. A frame with a low stop bit is dropped, and the receiver waits for the line to return high before it looks for a new start bit.
- R9: The FIFO holds FIFO_DEPTH (16) bytes. A byte arriving while the FIFO is full is dropped and sets rx_overflow, which stays set until the next 0xFF command.
- R10: irq is high exactly while the FIFO holds at least one byte.
- R11: After reset: pass-through mode is off, the FIFO is empty, midi_out is high, irq and rx_overflow are low, and status reads 0x80.
- R12: Command values other than 0xFF and 0x3F change neither the mode nor the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_addr | input | 1 | 0 selects data, 1 selects command/status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| midi_in | input | 1 | Serial MIDI input, idle high |
| midi_out | output | 1 | Serial MIDI output, idle high |
| irq | output | 1 | Receive interrupt request |
| rx_overflow | output | 1 | Sticky receive-overflow flag |

## Verification
The bench targets the gating rules. It writes data before pass-through mode is entered, while a frame is still going out, and while input is pending. A design that leaked any of these writes would put an unexpected frame on the line, and the serial monitor reports it. It feeds seventeen frames into a sixteen-entry FIFO. A design with an off-by-one depth, or one that let the newest byte overwrite the oldest, would show it in the read order and in the overflow flag. It issues the reset command with data already queued. A design that queued the acknowledge before flushing would lose 0xFE or leave stale bytes behind it. A frame with a bad stop bit must leave no trace, which catches a receiver that stores it or resynchronises in the middle of the low level.

// File: rtl/midi_uart_pkg.sv
// Shared constants for the MIDI serial port: command codes, the
// acknowledge byte, register addresses, status bit positions and the
// receiver state type.
package midi_uart_pkg;
    localparam logic [7:0] CMD_RESET     = 8'hFF;
    localparam logic [7:0] CMD_UART_MODE = 8'h3F;
    localparam logic [7:0] ACK_BYTE      = 8'hFE;

    localparam logic REG_DATA = 1'b0;
    localparam logic REG_CMD  = 1'b1;

    localparam int STS_NO_INPUT = 7;
    localparam int STS_TX_BUSY  = 6;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_t;
endpackage

// File: rtl/midi_tx.sv
// Serializer. Sends one byte as an 8N1 frame, with BIT_CYCLES clocks per bit.
// Assumes: start is only acted on while busy is low. Bytes offered while
// busy are ignored here, and the caller gates them.
module midi_tx #(
    parameter int BIT_CYCLES = 8000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] data,
    output logic       busy,
    output logic       txd
);
    localparam int CW = $clog2(BIT_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic [8:0]    shreg;
    logic [3:0]    remaining;

    // Frame sequencer: start bit, then data bits LSB first, then the stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            txd       <= 1'b1;
            cnt       <= '0;
            shreg     <= '0;
            remaining <= '0;
        end else if (!busy) begin
            if (start) begin
                busy      <= 1'b1;
                txd       <= 1'b0;
                shreg     <= {1'b1, data};
                remaining <= 4'd9;
                cnt       <= CW'(BIT_CYCLES - 1);
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else if (remaining == 4'd0) begin
            busy <= 1'b0;
            txd  <= 1'b1;
        end else begin
            txd       <= shreg[0];
            shreg     <= {1'b0, shreg[8:1]};
            remaining <= remaining - 1'b1;
            cnt       <= CW'(BIT_CYCLES - 1);
        end
    end

    a_r5_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !txd));
    a_r5_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);
endmodule

// File: rtl/midi_rx.sv
// Deserializer. Synchronises the line, finds a start bit, samples each
// bit in its middle, and checks the stop bit. Emits a one-cycle valid pulse
// with the byte. After a bad stop bit it waits for the line to return high.
// Assumes: BIT_CYCLES >= 4.
module midi_rx
    import midi_uart_pkg::*;
#(
    parameter int BIT_CYCLES = 8000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    output logic       valid,
    output logic [7:0] data
);
    localparam int CW   = $clog2(BIT_CYCLES + 1);
    localparam int HALF = BIT_CYCLES / 2;

    logic          sync1, sync2;
    rx_state_t     state;
    logic [CW-1:0] cnt;
    logic [2:0]    idx;
    logic [7:0]    shreg;

    // Two-stage synchroniser for the asynchronous serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= rxd;
            sync2 <= sync1;
        end
    end

    // Frame decoder: start check at half bit, then data and stop sampled in the middle of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (!sync2) begin
                        state <= RX_START;
                        cnt   <= CW'(HALF - 1);
                    end
                end
                RX_START: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (!sync2) begin
                        state <= RX_DATA;
                        cnt   <= CW'(BIT_CYCLES - 1);
                        idx   <= '0;
                    end else begin
                        state <= RX_IDLE;
                    end
                end
                RX_DATA: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        shreg <= {sync2, shreg[7:1]};
                        cnt   <= CW'(BIT_CYCLES - 1);
                        if (idx == 3'd7) state <= RX_STOP;
                        idx <= idx + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (sync2) begin
                        valid <= 1'b1;
                        data  <= shreg;
                        state <= RX_IDLE;
                    end else begin
                        state <= RX_WAIT_HIGH;
                    end
                end
                RX_WAIT_HIGH: begin
                    if (sync2) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    a_r8_no_byte_after_bad_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_WAIT_HIGH) |=> !valid);
endmodule

// File: rtl/midi_rx_fifo.sv
// Receive FIFO with flush, drop-on-full and a sticky overflow flag.
// Assumes: a flush in the same cycle as a push leaves only the pushed item.
// The overflow flag clears only on flush.
module midi_rx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic             overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             full, empty, do_pop, do_push;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer, level and overflow tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            overflow <= 1'b0;
        end else if (flush) begin
            rd_ptr   <= '0;
            wr_ptr   <= push ? AW'(1 % DEPTH) : '0;
            level    <= push ? LW'(1) : '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= wrap_inc(wr_ptr);
            if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
            if (do_push && !do_pop) level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
            if (push && !do_push) overflow <= 1'b1;
        end
    end

    // Storage write; a flush restarts writing at entry 0.
    always_ff @(posedge clk) begin
        if (flush) begin
            if (push) mem[0] <= din;
        end else if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    a_r9_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && level == LW'(DEPTH)) |=> (overflow && level == LW'(DEPTH)));
    a_r4_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && level != '0) |=> (level == $past(level) - 1'b1));
endmodule

// File: rtl/midi_uart_port.sv
// Host-facing MIDI port. Decodes the two registers, runs the command and
// acknowledge protocol, gates transmission and routes received bytes.
// Assumes: bus_rd and bus_wr are single-cycle strobes and are not both set.
// A received byte that completes in the same cycle as a command write is
// discarded, because the acknowledge takes the FIFO write port.
module midi_uart_port
    import midi_uart_pkg::*;
#(
    parameter int CLK_HZ     = 250_000_000,
    parameter int BAUD       = 31_250,
    parameter int FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       midi_in,
    output logic       midi_out,
    output logic       irq,
    output logic       rx_overflow
);
    localparam int BIT_CYCLES = CLK_HZ / BAUD;
    localparam int LW         = $clog2(FIFO_DEPTH + 1);

    logic          uart_mode;
    logic          cmd_wr, data_wr, data_rd;
    logic          is_reset_cmd, is_mode_cmd, ack_push;
    logic          tx_busy, tx_ready, tx_start;
    logic          rx_valid;
    logic [7:0]    rx_byte, fifo_head, fifo_din;
    logic [LW-1:0] fifo_level;
    logic          fifo_empty, fifo_push;
    logic [7:0]    status;

    assign cmd_wr       = bus_wr && (bus_addr == REG_CMD);
    assign data_wr      = bus_wr && (bus_addr == REG_DATA);
    assign data_rd      = bus_rd && (bus_addr == REG_DATA);
    assign is_reset_cmd = cmd_wr && (bus_wdata == CMD_RESET);
    assign is_mode_cmd  = cmd_wr && (bus_wdata == CMD_UART_MODE);
    assign ack_push     = is_reset_cmd || is_mode_cmd;

    assign fifo_empty = (fifo_level == '0);
    assign tx_ready   = !tx_busy && fifo_empty;
    assign tx_start   = data_wr && uart_mode && tx_ready;

    assign fifo_push = ack_push || (rx_valid && uart_mode && !cmd_wr);
    assign fifo_din  = ack_push ? ACK_BYTE : rx_byte;

    // Mode register: set by the pass-through command, cleared by reset command.
    always_ff @(posedge clk) begin
        if (!rst_n)            uart_mode <= 1'b0;
        else if (is_reset_cmd) uart_mode <= 1'b0;
        else if (is_mode_cmd)  uart_mode <= 1'b1;
    end

    // Status word: active-low availability flags in the two top bits.
    always_comb begin
        status               = '0;
        status[STS_NO_INPUT] = fifo_empty;
        status[STS_TX_BUSY]  = !tx_ready;
    end

    // Read mux: status at the command address, FIFO head (or zero) at data.
    always_comb begin
        if (bus_addr == REG_CMD) bus_rdata = status;
        else if (fifo_empty)     bus_rdata = 8'h00;
        else                     bus_rdata = fifo_head;
    end

    assign irq = !fifo_empty;

    midi_tx #(.BIT_CYCLES(BIT_CYCLES)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tx_start),
        .data  (bus_wdata),
        .busy  (tx_busy),
        .txd   (midi_out)
    );

    midi_rx #(.BIT_CYCLES(BIT_CYCLES)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .rxd   (midi_in),
        .valid (rx_valid),
        .data  (rx_byte)
    );

    midi_rx_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (is_reset_cmd),
        .push     (fifo_push),
        .din      (fifo_din),
        .pop      (data_rd),
        .head     (fifo_head),
        .level    (fifo_level),
        .overflow (rx_overflow)
    );

    a_r2_reset_cmd_leaves_ack: assert property (@(posedge clk) disable iff (!rst_n)
        is_reset_cmd |=> (fifo_level == LW'(1) && !uart_mode && !rx_overflow));
    a_r3_mode_cmd_enters: assert property (@(posedge clk) disable iff (!rst_n)
        is_mode_cmd |=> (uart_mode && fifo_level != '0));
    a_r12_other_cmd_no_mode_change: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !ack_push) |=> $stable(uart_mode));
    a_r6_hold_off_on_pending_input: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && fifo_level != '0 && !tx_busy) |=> !tx_busy);
    a_r7_no_send_outside_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !uart_mode && !tx_busy) |=> !tx_busy);
endmodule

// File: tb/sim_midi_uart_port.sv
// Scoreboard bench: tasks queue the expected bytes; host reads and a serial
// line monitor pop the queues and compare.
module sim_midi_uart_port;
    localparam int BITC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       midi_in = 1'b1;
    logic       midi_out, irq, rx_overflow;

    int checks = 0;
    int errors = 0;
    logic [7:0] rx_exp[$];
    logic [7:0] tx_exp[$];

    always #2 clk = ~clk;

    midi_uart_port #(.CLK_HZ(250_000), .BAUD(31_250), .FIFO_DEPTH(16)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .midi_in(midi_in), .midi_out(midi_out), .irq(irq), .rx_overflow(rx_overflow)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read_status(input string req, input logic [7:0] exp);
        logic [7:0] v;
        bus_read(1'b1, v);
        chk(req, v, exp);
    endtask

    // Pop one byte over the bus and compare it with the scoreboard head.
    task automatic read_expect(input string req);
        logic [7:0] v, e;
        bus_read(1'b0, v);
        e = (rx_exp.size() != 0) ? rx_exp.pop_front() : 8'h00;
        chk(req, v, e);
    endtask

    task automatic send_serial(input logic [7:0] b, input logic good_stop);
        @(negedge clk);
        midi_in = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            midi_in = b[i];
            repeat (BITC) @(negedge clk);
        end
        midi_in = good_stop;
        repeat (BITC) @(negedge clk);
        midi_in = 1'b1;
        repeat (BITC) @(negedge clk);
    endtask

    task automatic wait_tx_idle();
        logic [7:0] v;
        for (int i = 0; i < 500; i++) begin
            bus_read(1'b1, v);
            if (v[6] == 1'b0) break;
        end
        repeat (2 * BITC) @(negedge clk);
    endtask

    // Line monitor: decodes each frame on midi_out and compares with tx_exp (R5).
    initial begin
        logic [7:0] got, e;
        forever begin
            @(negedge midi_out);
            repeat (BITC / 2) @(posedge clk);
            #1 chk("R5 start bit", {7'd0, midi_out}, 8'h00);
            for (int i = 0; i < 8; i++) begin
                repeat (BITC) @(posedge clk);
                #1 got[i] = midi_out;
            end
            repeat (BITC) @(posedge clk);
            #1 chk("R5 stop bit", {7'd0, midi_out}, 8'h01);
            if (tx_exp.size() == 0) begin
                checks++; errors++;
                $display("FAIL R6/R7 unexpected frame: got %h expected none", got);
            end else begin
                e = tx_exp.pop_front();
                chk("R5 frame data", got, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 / R1 reset state
        read_status("R11 status after reset", 8'h80);
        chk("R11 irq", {7'd0, irq}, 8'h00);
        chk("R11 midi_out idle", {7'd0, midi_out}, 8'h01);
        chk("R11 overflow", {7'd0, rx_overflow}, 8'h00);

        // R7 command-only mode: writes and serial input have no effect
        bus_write(1'b0, 8'h12);
        repeat (12 * BITC) @(negedge clk);
        send_serial(8'h42, 1'b1);
        read_status("R7 input not stored outside mode", 8'h80);

        // R12 unknown command
        bus_write(1'b1, 8'h55);
        read_status("R12 unknown command ignored", 8'h80);
        bus_write(1'b0, 8'h13);
        repeat (12 * BITC) @(negedge clk);

        // R3 enter pass-through, ack 0xFE; R10 irq; R1 bit 6 on pending input
        bus_write(1'b1, 8'h3F);
        rx_exp.push_back(8'hFE);
        read_status("R3 ack pending, R1 flags", 8'h40);
        chk("R10 irq with pending byte", {7'd0, irq}, 8'h01);
        read_expect("R3 ack byte");
        read_status("R1 empty after read", 8'h80);
        chk("R10 irq low when empty", {7'd0, irq}, 8'h00);
        begin
            logic [7:0] v;
            bus_read(1'b0, v);
            chk("R4 empty read returns zero", v, 8'h00);
        end

        // R5 transmit, R6 write while busy dropped
        tx_exp.push_back(8'hA5);
        bus_write(1'b0, 8'hA5);
        read_status("R1 busy flag while sending", 8'hC0);
        bus_write(1'b0, 8'h11);
        wait_tx_idle();
        tx_exp.push_back(8'h3C);
        bus_write(1'b0, 8'h3C);
        wait_tx_idle();

        // R8 / R4 receive in order
        send_serial(8'h5A, 1'b1); rx_exp.push_back(8'h5A);
        send_serial(8'h81, 1'b1); rx_exp.push_back(8'h81);
        read_expect("R8 R4 first byte");
        read_expect("R8 R4 second byte");

        // R6 hold-off while input pending
        send_serial(8'h77, 1'b1); rx_exp.push_back(8'h77);
        read_status("R6 not ready with input pending", 8'h40);
        bus_write(1'b0, 8'h99);
        repeat (12 * BITC) @(negedge clk);
        read_expect("R6 pending byte intact");

        // R8 bad stop bit dropped
        send_serial(8'h33, 1'b0);
        repeat (2 * BITC) @(negedge clk);
        read_status("R8 framing error dropped", 8'h80);

        // R9 overflow: seventeen bytes into sixteen entries
        for (int i = 0; i < 17; i++) begin
            send_serial(8'h20 + 8'(i), 1'b1);
            if (i < 16) rx_exp.push_back(8'h20 + 8'(i));
        end
        chk("R9 overflow flag set", {7'd0, rx_overflow}, 8'h01);
        for (int i = 0; i < 16; i++) read_expect("R9 kept byte order");
        read_status("R9 newest byte dropped", 8'h80);
        chk("R9 overflow sticky", {7'd0, rx_overflow}, 8'h01);

        // R2 reset command with bytes queued
        send_serial(8'h61, 1'b1);
        send_serial(8'h62, 1'b1);
        bus_write(1'b1, 8'hFF);
        rx_exp.push_back(8'hFE);
        chk("R2 overflow cleared", {7'd0, rx_overflow}, 8'h00);
        read_status("R2 one byte queued", 8'h40);
        read_expect("R2 ack after flush");
        read_status("R2 nothing behind ack", 8'h80);
        bus_write(1'b0, 8'h44);
        repeat (12 * BITC) @(negedge clk);
        send_serial(8'h45, 1'b1);
        read_status("R7 mode left after reset command", 8'h80);

        chk("R5 all frames seen", 8'(tx_exp.size()), 8'h00);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule